// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block holds the two-word command that software fills in to send a message to another processor, or to a group of processors. The high word carries an explicit destination ID. The low word carries the vector, the delivery mode, the level and trigger flags, and a two-bit shorthand that can replace the explicit destination with "self", "everyone" or "everyone but me". A software write to the low word starts the send. The unit takes a snapshot of the resolved destination, raises a valid/ready message channel, and sets a busy bit that software can poll in the low word until the receiver takes the message.

Software reaches both words through a plain 32-bit register bus with address, write enable, write data and a combinational read port. The local processor ID comes in on its own input and is used when the shorthand targets self. A command whose delivery mode is remote read also steps a two-bit status field in the low word: in-progress while the message waits, valid once it has left.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid is 0 and both the low word (offset 0x300) and the high word (offset 0x310) read as 0.
- R2: A write to the low word while the unit is idle raises msg_valid on the next cycle, and bit 12 (busy) of the low word reads 1 while msg_valid is 1.
- R3: Low-word fields vector [7:0], delivery mode [10:8], level assert [14] and trigger level [15] appear unchanged on msg_vector, msg_mode, msg_level_assert and msg_trig_level, and read back in the same positions.
- R4: Shorthand [19:18] = 00 sends to the ID held in high-word bits [31:24]: msg_dest is that ID, msg_bcast is 0 and msg_incl_self is 1.
- R5: Shorthand 01 sends to self: msg_dest equals local_id, msg_bcast is 0 and msg_incl_self is 1.
- R6: Shorthand 10 broadcasts including self: msg_bcast is 1, msg_incl_self is 1 and msg_dest is all ones.
- R7: Shorthand 11 broadcasts excluding self: msg_bcast is 1, msg_incl_self is 0 and msg_dest is all ones.
- R8: msg_valid and the busy bit clear on the clock edge where msg_valid and msg_ready are both 1, including the case where msg_ready is already high when the send starts.
- R9: A low-word write while busy is ignored. The message outputs and the low-word readback keep their values.
- R10: A high-word write never starts a send. It is accepted at any time, reads back in bits [31:24] with all other bits 0, and does not alter a message already in flight.
- R11: Remote-read status [17:16] reads 01 while a command with delivery mode 011 is busy and 10 after it leaves. A send with any other mode sets it to 00. Bits 12, 16 and 17 cannot be written.
- R12: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and every message field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| local_id | input | 8 | ID of this processor |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Receiver accepts message |
| msg_dest | output | 8 | Resolved destination ID |
| msg_bcast | output | 1 | Message goes to all processors |
| msg_incl_self | output | 1 | Sender is among the targets |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level_assert | output | 1 | Level assert (1) or deassert (0) |
| msg_trig_level | output | 1 | Trigger mode, level (1) or edge (0) |

## Verification
The bench uses the default parameters: a 12-bit window with the command words at 0x300 and 0x310, and 8-bit IDs. With 8-bit IDs the all-ones ID can be used both as an explicit destination and as the broadcast code, so a field-mode send to ID 0xFF can be checked against a true broadcast. The bench holds the receiver stalled to show that a busy write has no effect, that a high-word write during a stall has no effect, and that the message holds steady. It also holds ready high before a launch to exercise the clear in the same cycle as the handshake.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef enum logic [1:0] {
    RR_INVALID = 2'b00,
    RR_PENDING = 2'b01,
    RR_VALID   = 2'b10,
    RR_RSVD    = 2'b11
  } rrstat_e;

  localparam logic [2:0] DM_REMOTE_READ = 3'b011;

  typedef struct packed {
    shorthand_e sh;
    logic       trig;
    logic       lvl;
    logic [2:0] mode;
    logic [7:0] vec;
  } lo_cmd_t;

endpackage

// File: rtl/ipi_regs.sv
module ipi_regs #(
  parameter int ID_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lo_accept,
  input  logic                hi_we,
  input  ipi_pkg::lo_cmd_t    lo_in,
  input  logic [ID_W-1:0]     hi_in,
  output ipi_pkg::lo_cmd_t    lo_q,
  output logic [ID_W-1:0]     hi_q
);
  ipi_pkg::lo_cmd_t lo_d;
  logic [ID_W-1:0]  hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (lo_accept) lo_d = lo_in;
    if (hi_we)     hi_d = hi_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve #(
  parameter int ID_W = 8
) (
  input  ipi_pkg::shorthand_e sh,
  input  logic [ID_W-1:0]     hi_id,
  input  logic [ID_W-1:0]     local_id,
  output logic [ID_W-1:0]     dest,
  output logic                bcast,
  output logic                incl_self
);
  always_comb begin
    dest      = hi_id;
    bcast     = 1'b0;
    incl_self = 1'b1;
    unique case (sh)
      ipi_pkg::SH_FIELD: dest = hi_id;
      ipi_pkg::SH_SELF:  dest = local_id;
      ipi_pkg::SH_ALL: begin
        dest  = '1;
        bcast = 1'b1;
      end
      ipi_pkg::SH_OTHERS: begin
        dest      = '1;
        bcast     = 1'b1;
        incl_self = 1'b0;
      end
      default: dest = hi_id;
    endcase
  end
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch #(
  parameter int ID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [2:0]        mode_in,
  input  logic [ID_W-1:0]   dest_in,
  input  logic              bcast_in,
  input  logic              incl_in,
  input  logic              ready,
  output logic              busy,
  output ipi_pkg::rrstat_e  rr,
  output logic [ID_W-1:0]   dest,
  output logic              bcast,
  output logic              incl
);
  logic              busy_d;
  ipi_pkg::rrstat_e  rr_d;
  logic              tgt_en;
  logic              done;

  assign done   = busy && ready;
  assign tgt_en = launch;

  always_comb begin
    busy_d = busy;
    rr_d   = rr;
    if (launch) begin
      busy_d = 1'b1;
      rr_d   = (mode_in == ipi_pkg::DM_REMOTE_READ) ? ipi_pkg::RR_PENDING
                                                     : ipi_pkg::RR_INVALID;
    end else if (done) begin
      busy_d = 1'b0;
      if (rr == ipi_pkg::RR_PENDING) rr_d = ipi_pkg::RR_VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rr   <= ipi_pkg::RR_INVALID;
    end else begin
      busy <= busy_d;
      rr   <= rr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest  <= '0;
      bcast <= 1'b0;
      incl  <= 1'b0;
    end else if (tgt_en) begin
      dest  <= dest_in;
      bcast <= bcast_in;
      incl  <= incl_in;
    end
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          ID_W    = 8,
  parameter logic [11:0] LO_ADDR = 12'h300,
  parameter logic [11:0] HI_ADDR = 12'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ID_W-1:0]   local_id,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ID_W-1:0]   msg_dest,
  output logic              msg_bcast,
  output logic              msg_incl_self,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level_assert,
  output logic              msg_trig_level
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  ipi_pkg::lo_cmd_t  lo_in, lo_q;
  logic [ID_W-1:0]   hi_q;
  logic [ID_W-1:0]   res_dest;
  logic              res_bcast, res_incl;
  logic              busy, lo_hit, hi_hit, lo_accept;
  ipi_pkg::rrstat_e  rr;

  assign lo_hit    = reg_we && (reg_addr == LO_A);
  assign hi_hit    = reg_we && (reg_addr == HI_A);
  assign lo_accept = lo_hit && !busy;

  assign lo_in.sh   = ipi_pkg::shorthand_e'(reg_wdata[19:18]);
  assign lo_in.trig = reg_wdata[15];
  assign lo_in.lvl  = reg_wdata[14];
  assign lo_in.mode = reg_wdata[10:8];
  assign lo_in.vec  = reg_wdata[7:0];

  ipi_regs #(.ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lo_accept(lo_accept), .hi_we(hi_hit),
    .lo_in(lo_in), .hi_in(reg_wdata[DATA_W-1 -: ID_W]),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  ipi_dest_resolve #(.ID_W(ID_W)) u_res (
    .sh(lo_in.sh), .hi_id(hi_q), .local_id(local_id),
    .dest(res_dest), .bcast(res_bcast), .incl_self(res_incl)
  );

  ipi_launch #(.ID_W(ID_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .launch(lo_accept), .mode_in(lo_in.mode),
    .dest_in(res_dest), .bcast_in(res_bcast), .incl_in(res_incl),
    .ready(msg_ready), .busy(busy), .rr(rr),
    .dest(msg_dest), .bcast(msg_bcast), .incl(msg_incl_self)
  );

  assign msg_valid        = busy;
  assign msg_vector       = lo_q.vec;
  assign msg_mode         = lo_q.mode;
  assign msg_level_assert = lo_q.lvl;
  assign msg_trig_level   = lo_q.trig;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == LO_A) begin
      reg_rdata[19:18] = lo_q.sh;
      reg_rdata[17:16] = rr;
      reg_rdata[15]    = lo_q.trig;
      reg_rdata[14]    = lo_q.lvl;
      reg_rdata[12]    = busy;
      reg_rdata[10:8]  = lo_q.mode;
      reg_rdata[7:0]   = lo_q.vec;
    end else if (reg_addr == HI_A) begin
      reg_rdata[DATA_W-1 -: ID_W] = hi_q;
    end
  end
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          ID_W    = 8,
  parameter logic [11:0] LO_ADDR = 12'h300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [ID_W-1:0]   msg_dest,
  input logic              msg_bcast,
  input logic [7:0]        msg_vector
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == LO_A && !msg_valid) |=> msg_valid);

  p_busy_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LO_A) |-> (reg_rdata[12] == msg_valid));

  p_bcast_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_bcast) |-> (msg_dest == '1));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == LO_A && msg_valid && !msg_ready) |=> $stable(msg_vector));

  p_no_spont_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !(reg_we && reg_addr == LO_A)) |=> !msg_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) &&
                                   $stable(msg_bcast) && $stable(msg_vector)));
endmodule

bind ipi_cmd_unit ipi_cmd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dest(msg_dest), .msg_bcast(msg_bcast), .msg_vector(msg_vector)
);

// File: tb/sim_ipi_cmd_unit.sv
module sim_ipi_cmd_unit;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  logic        clk, rst_n, reg_we, msg_ready, msg_valid;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  local_id, msg_dest, msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_bcast, msg_incl_self, msg_level_assert, msg_trig_level;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  ipi_cmd_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .local_id(local_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_bcast(msg_bcast), .msg_incl_self(msg_incl_self),
    .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_level_assert(msg_level_assert), .msg_trig_level(msg_trig_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {hi_id, shorthand, vector, mode, exp_dest, exp_bcast, exp_incl}
  localparam int NV = 5;
  localparam logic [30:0] VEC [NV] = '{
    {8'h12, 2'b00, 8'h30, 3'd0, 8'h12, 1'b0, 1'b1},  // R4
    {8'h12, 2'b01, 8'h31, 3'd5, 8'h5A, 1'b0, 1'b1},  // R5
    {8'h00, 2'b10, 8'hFF, 3'd6, 8'hFF, 1'b1, 1'b1},  // R6
    {8'hA5, 2'b11, 8'h00, 3'd0, 8'hFF, 1'b1, 1'b0},  // R7
    {8'hFF, 2'b00, 8'h7E, 3'd4, 8'hFF, 1'b0, 1'b1}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic handshake();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  function automatic logic [31:0] mk_lo(logic [1:0] sh, logic [1:0] rr, logic trig,
                                        logic lvl, logic busy, logic [2:0] mode, logic [7:0] vec);
    return {12'h0, sh, rr, trig, lvl, 1'b0, busy, 1'b0, mode, vec};
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = LO; reg_wdata = '0;
    msg_ready = 1'b0; local_id = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid", {31'h0, msg_valid}, 32'h0);
    rd(LO, r); chk("R1 lo", r, 32'h0);
    rd(HI, r); chk("R1 hi", r, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [7:0] hid, vec, ed;
      logic [1:0] sh;
      logic [2:0] md;
      logic eb, ei, lv, tg;
      {hid, sh, vec, md, ed, eb, ei} = VEC[i];
      lv = i[0]; tg = i[1];
      wr(HI, {hid, 24'h0});
      wr(LO, mk_lo(sh, 2'b00, tg, lv, 1'b0, md, vec));
      chk("R2 valid", {31'h0, msg_valid}, 32'h1);
      chk("R4-7 dest", {24'h0, msg_dest}, {24'h0, ed});
      chk("R4-7 bcast/incl", {30'h0, msg_bcast, msg_incl_self}, {30'h0, eb, ei});
      chk("R3 fields", {16'h0, msg_trig_level, msg_level_assert, 3'b0, msg_mode, msg_vector},
          {16'h0, tg, lv, 3'b0, md, vec});
      rd(LO, r); chk("R2 R3 readback", r, mk_lo(sh, 2'b00, tg, lv, 1'b1, md, vec));
      handshake();
      chk("R8 cleared", {31'h0, msg_valid}, 32'h0);
      rd(LO, r); chk("R8 busy bit", {31'h0, r[12]}, 32'h0);
    end

    // R11 remote read status
    wr(LO, mk_lo(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 3'd3, 8'h40));
    rd(LO, r); chk("R11 pending", {30'h0, r[17:16]}, 32'h1);
    handshake();
    rd(LO, r); chk("R11 valid", {30'h0, r[17:16]}, 32'h2);
    // R11 read-only bits: try to write 17:16=11 and bit 12
    wr(LO, mk_lo(2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 3'd0, 8'h41));
    rd(LO, r); chk("R11 ro bits", r, mk_lo(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 3'd0, 8'h41));
    handshake();
    rd(LO, r); chk("R11 invalid", r, mk_lo(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0, 8'h41));

    // R9 R10 R12 busy behaviour with stalled receiver
    wr(HI, 32'h33000000);
    wr(LO, mk_lo(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 3'd2, 8'h11));
    wr(LO, mk_lo(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 3'd7, 8'h22));
    chk("R9 vector kept", {24'h0, msg_vector}, 32'h11);
    rd(LO, r); chk("R9 readback kept", r, mk_lo(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 3'd2, 8'h11));
    wr(HI, 32'h77ABCDEF);
    chk("R10 dest kept", {24'h0, msg_dest}, 32'h33);
    rd(HI, r); chk("R10 hi readback", r, 32'h77000000);
    repeat (3) @(negedge clk);
    chk("R12 still valid", {31'h0, msg_valid}, 32'h1);
    chk("R12 bcast held", {31'h0, msg_bcast}, 32'h0);
    handshake();
    wr(HI, 32'h44000000);
    @(negedge clk);
    chk("R10 no send", {31'h0, msg_valid}, 32'h0);

    // R8 ready already high at launch
    msg_ready = 1'b1;
    wr(LO, mk_lo(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 3'd0, 8'h55));
    chk("R8 shown one cycle", {31'h0, msg_valid}, 32'h1);
    chk("R5 self dest", {24'h0, msg_dest}, 32'h5A);
    @(negedge clk);
    chk("R8 early ready", {31'h0, msg_valid}, 32'h0);
    msg_ready = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule